// File: doc/BRIEF.md
# GPIO Change Interrupt Controller

This block is the interrupt half of an 8-bit general-purpose I/O port. It holds a small register file: configuration, direction, output configuration, interrupt mask and port data. Each pin set up as an input is watched for a change of level. Every change is latched into a sticky status register, whether or not that pin is masked. An active-low alert line tells the host that an enabled, unmasked change is waiting.

The host reaches the registers through a plain single-cycle register port. Read data comes back one cycle after the read strobe. A byte read of the status register returns the pending bits and clears them. The host can also run an alert-response query by pulsing the alert-response strobe. If the block is holding the alert line at that moment, it claims the query on a one-cycle reply output and releases the alert line. The status bits stay as they are until the host reads them. The line remains released until a fresh status bit appears.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, addresses 0, 1, 2, 3 and 4 read 00h and address 5 reads FFh. `alert_no` is high and `ara_hit_o` is low.
- R2: Writes store into configuration (address 0), direction (1), output configuration (2) and mask (4), and reads return the stored byte. Writes to status (3) are ignored. Addresses 6 and 7 read 00h. `rdata_o` is valid in the cycle after the cycle where `rd_en_i` is high.
- R3: A direction bit of 1 makes that pin an input. A level change on an input pin sets the matching status bit. The pin passes two synchronizer flops and an edge compare, so the bit is set on the third rising clock edge after the change. Changes on output pins set nothing.
- R4: A change is recorded in status whatever the mask bits and the global enable are.
- R5: `alert_no` is low only when configuration bit 0 is 1 and some status bit whose mask bit is 1 is set, and no alert-response claim is in force.
- R6: When `ara_i` is high while `alert_no` is low, `ara_hit_o` is high for the following cycle and `alert_no` goes high. The status bits are not cleared. When `ara_i` is high while `alert_no` is high, `ara_hit_o` stays low.
- R7: A read of address 3 returns the status byte, clears every status bit, and so releases `alert_no`.
- R8: Several changes on one pin between two status reads leave a single set bit.
- R9: If a pin change reaches the status register in the same cycle as a status read, that bit stays set after the read.
- R10: After an alert-response claim, `alert_no` stays high until a new status bit is set. When that happens, the alert line follows R5 again.
- R11: A read of address 5 returns the synchronized pin level on input pins and the written data bit on output pins. `pin_o` drives the written data byte, and `pin_oe_o` is the inverse of the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| pin_i | input | 8 | Pin levels from the pads |
| pin_o | output | 8 | Output data to the pads |
| pin_oe_o | output | 8 | Output enables, 1 = drive |
| ara_i | input | 1 | Alert-response query strobe |
| ara_hit_o | output | 1 | Block claims the query, one cycle |
| alert_no | output | 1 | Alert line, active low |

## Verification
The bench builds the block with its default parameters: an 8-pin port and a two-stage synchronizer. With these defaults, every pin can be an input, an output or masked. The fixed three-edge capture latency also lets the bench place a pin change exactly in the cycle of a status read. Random sequences of pin changes, mask and enable writes, alert-response queries and status reads are run against a bench model of the sticky status and the alert-response claim. This brings in reach the mixes where a claim and a new change interact.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG  = 3'd0,
    REG_DIR  = 3'd1,
    REG_OCFG = 3'd2,
    REG_STAT = 3'd3,
    REG_MASK = 3'd4,
    REG_DATA = 3'd5
  } reg_addr_e;

  localparam int IE_BIT = 0;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_s_o,
  output logic [W-1:0] toggle_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = pin_i;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stage_q[STAGES-1];
  end

  assign pin_s_o  = stage_q[STAGES-1];
  assign toggle_o = stage_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      cfg_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      ocfg_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      data_o
);
  logic we_cfg, we_dir, we_ocfg, we_mask, we_data;
  logic [W-1:0] cfg_q, dir_q, ocfg_q, mask_q, data_q;

  always_comb begin
    we_cfg  = wr_en_i && (addr_i == REG_CFG);
    we_dir  = wr_en_i && (addr_i == REG_DIR);
    we_ocfg = wr_en_i && (addr_i == REG_OCFG);
    we_mask = wr_en_i && (addr_i == REG_MASK);
    we_data = wr_en_i && (addr_i == REG_DATA);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      dir_q  <= '0;
      ocfg_q <= '0;
      mask_q <= '0;
      data_q <= '1;
    end else begin
      if (we_cfg)  cfg_q  <= wdata_i;
      if (we_dir)  dir_q  <= wdata_i;
      if (we_ocfg) ocfg_q <= wdata_i;
      if (we_mask) mask_q <= wdata_i;
      if (we_data) data_q <= wdata_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign dir_o  = dir_q;
  assign ocfg_o = ocfg_q;
  assign mask_o = mask_q;
  assign data_o = data_q;
endmodule

// File: rtl/gpio_irq_alert.sv
module gpio_irq_alert #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ie_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] toggle_i,
  input  logic         rd_status_i,
  input  logic         ara_i,
  output logic [W-1:0] status_o,
  output logic         alert_no,
  output logic         ara_hit_o
);
  logic [W-1:0] status_q, status_d, kept, chg, new_set;
  logic         blk_q, blk_d;
  logic         hit_q, hit_d;
  logic         alert_act;

  always_comb begin
    kept      = rd_status_i ? '0 : status_q;
    chg       = toggle_i & dir_i;
    status_d  = kept | chg;
    new_set   = chg & ~kept;
    alert_act = ie_i && (|(status_q & mask_i)) && !blk_q;
    hit_d     = ara_i && alert_act;
    if (|new_set)  blk_d = 1'b0;
    else if (hit_d) blk_d = 1'b1;
    else            blk_d = blk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      blk_q    <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      blk_q    <= blk_d;
      hit_q    <= hit_d;
    end
  end

  assign status_o  = status_q;
  assign alert_no  = !alert_act;
  assign ara_hit_o = hit_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC_FLOP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe_o,
  input  logic              ara_i,
  output logic              ara_hit_o,
  output logic              alert_no
);
  logic [W-1:0] cfg_w, dir_w, ocfg_w, mask_w, data_w;
  logic [W-1:0] pin_s_w, toggle_w, status_w;
  logic [W-1:0] rd_val, rdata_q;
  logic         rd_status;

  gpio_irq_sync #(.W(W), .STAGES(SYNC_FLOP)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (pin_i),
    .pin_s_o  (pin_s_w),
    .toggle_o (toggle_w)
  );

  gpio_irq_regs #(.W(W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cfg_o   (cfg_w),
    .dir_o   (dir_w),
    .ocfg_o  (ocfg_w),
    .mask_o  (mask_w),
    .data_o  (data_w)
  );

  assign rd_status = rd_en_i && (addr_i == REG_STAT);

  gpio_irq_alert #(.W(W)) u_alert (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ie_i        (cfg_w[IE_BIT]),
    .mask_i      (mask_w),
    .dir_i       (dir_w),
    .toggle_i    (toggle_w),
    .rd_status_i (rd_status),
    .ara_i       (ara_i),
    .status_o    (status_w),
    .alert_no    (alert_no),
    .ara_hit_o   (ara_hit_o)
  );

  always_comb begin
    case (addr_i)
      REG_CFG:  rd_val = cfg_w;
      REG_DIR:  rd_val = dir_w;
      REG_OCFG: rd_val = ocfg_w;
      REG_STAT: rd_val = status_w;
      REG_MASK: rd_val = mask_w;
      REG_DATA: rd_val = (dir_w & pin_s_w) | (~dir_w & data_w);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o  = rdata_q;
  assign pin_o    = data_w;
  assign pin_oe_o = ~dir_w;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rd_en_i,
  input logic [2:0]   addr_i,
  input logic         ara_i,
  input logic         alert_no,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] status_i,
  input logic [W-1:0] dir_i,
  input logic         ie_i
);
  p_no_alert_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |-> alert_no);

  p_read_returns_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 3'd3) |=> (rdata_o == $past(status_i)));

  p_sticky_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && addr_i == 3'd3) |=> ((status_i & $past(status_i)) == $past(status_i)));

  p_claim_keeps_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ara_i && !alert_no) |=> ((status_i & $past(status_i)) == $past(status_i)
                               || $past(rd_en_i && addr_i == 3'd3)));

  p_outputs_not_captured_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & ~$past(status_i) & ~$past(dir_i)) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .ara_i    (ara_i),
  .alert_no (alert_no),
  .rdata_o  (rdata_o),
  .status_i (status_w),
  .dir_i    (dir_w),
  .ie_i     (cfg_w[0])
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  logic       clk, rst_n, wr_en, rd_en, ara;
  logic [2:0] addr;
  logic [7:0] wdata, pins;
  logic [7:0] rdata_o, pin_o, pin_oe_o;
  logic       ara_hit_o, alert_no;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  gpio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o),
    .pin_i(pins), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .ara_i(ara), .ara_hit_o(ara_hit_o), .alert_no(alert_no)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata_o;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic query(output logic hit);
    ara = 1'b1;
    @(negedge clk);
    ara = 1'b0;
    hit = ara_hit_o;
  endtask

  function automatic logic [7:0] data_view(input logic [7:0] dir, input logic [7:0] p,
                                           input logic [7:0] latch);
    return (dir & p) | (~dir & latch);
  endfunction

  function automatic logic exp_alert_n(input logic ie, input logic [7:0] st,
                                       input logic [7:0] mk, input logic blk);
    return !(ie && (|(st & mk)) && !blk);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       h;
    logic [7:0] st_m, mk_m, old;
    logic       ie_m, blk_m;
    wr_en = 0; rd_en = 0; ara = 0; addr = 0; wdata = 0; pins = 8'h00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset reg", d, (a == 5) ? 8'hFF : 8'h00);
    end
    chk("R1 alert idle", {7'b0, alert_no}, 8'h01);
    chk("R1 hit idle", {7'b0, ara_hit_o}, 8'h00);

    // R2 register access
    wr(3'd0, 8'h5A); wr(3'd1, 8'h00); wr(3'd2, 8'hC3); wr(3'd4, 8'h96);
    rd(3'd0, d); chk("R2 cfg", d, 8'h5A);
    rd(3'd2, d); chk("R2 ocfg", d, 8'hC3);
    rd(3'd4, d); chk("R2 mask", d, 8'h96);
    wr(3'd3, 8'hFF); rd(3'd3, d); chk("R2 status write ignored", d, 8'h00);
    rd(3'd6, d); chk("R2 unused 6", d, 8'h00);
    rd(3'd7, d); chk("R2 unused 7", d, 8'h00);
    wr(3'd0, 8'h00); wr(3'd4, 8'h00);

    // R11 data view
    wr(3'd1, 8'h0F); wr(3'd5, 8'hA5);
    pins = 8'h3C; settle();
    rd(3'd5, d); chk("R11 data read", d, data_view(8'h0F, 8'h3C, 8'hA5));
    chk("R11 pin_o", pin_o, 8'hA5);
    chk("R11 pin_oe", pin_oe_o, 8'hF0);
    rd(3'd3, d);

    // R3 only inputs captured
    pins = pins ^ 8'h12; settle();
    rd(3'd3, d); chk("R3 input capture", d, 8'h02);

    // R4 capture with mask and enable off, R5 alert stays high
    pins = pins ^ 8'h01; settle();
    chk("R5 no alert when disabled", {7'b0, alert_no}, 8'h01);
    wr(3'd4, 8'h01); @(negedge clk);
    chk("R5 no alert mask only", {7'b0, alert_no}, 8'h01);
    wr(3'd0, 8'h01); @(negedge clk);
    chk("R5 alert on", {7'b0, alert_no}, 8'h00);

    // R6 alert-response claim keeps status
    query(h);
    chk("R6 hit", {7'b0, h}, 8'h01);
    chk("R6 alert released", {7'b0, alert_no}, 8'h01);
    @(negedge clk);
    chk("R6 hit one cycle", {7'b0, ara_hit_o}, 8'h00);
    rd(3'd3, d); chk("R4 R6 status kept", d, 8'h01);
    chk("R7 alert after read", {7'b0, alert_no}, 8'h01);
    rd(3'd3, d); chk("R7 cleared", d, 8'h00);
    query(h); chk("R6 no claim when idle", {7'b0, h}, 8'h00);

    // R10 claim holds until new bit
    pins = pins ^ 8'h01; settle();
    chk("R5 alert again", {7'b0, alert_no}, 8'h00);
    query(h);
    repeat (10) @(negedge clk);
    chk("R10 stays released", {7'b0, alert_no}, 8'h01);
    pins = pins ^ 8'h04; settle();
    chk("R10 new bit reasserts", {7'b0, alert_no}, 8'h00);
    rd(3'd3, d); chk("R10 status", d, 8'h05);

    // R8 repeated changes
    for (int k = 0; k < 3; k++) begin pins = pins ^ 8'h08; settle(); end
    rd(3'd3, d); chk("R8 single bit", d, 8'h08);

    // R9 change in the read cycle
    pins = pins ^ 8'h02;
    @(negedge clk); @(negedge clk);
    rd(3'd3, d); chk("R9 read before capture", d, 8'h00);
    rd(3'd3, d); chk("R9 change kept", d, 8'h02);

    // random phase with bench model
    void'($urandom(32'd20240611));
    wr(3'd1, 8'hFF);
    settle(); rd(3'd3, d);
    st_m = 8'h00; mk_m = 8'h00; ie_m = 1'b0; blk_m = 1'b0;
    wr(3'd0, 8'h00); wr(3'd4, 8'h00);
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: begin
          logic [7:0] nb;
          old = pins;
          pins = 8'($urandom);
          settle();
          nb = (old ^ pins) & ~st_m;
          if (nb != 0) blk_m = 1'b0;
          st_m = st_m | (old ^ pins);
        end
        1: begin
          rd(3'd3, d); chk("R7 random status", d, st_m);
          st_m = 8'h00;
        end
        2: begin
          logic act;
          act = !exp_alert_n(ie_m, st_m, mk_m, blk_m);
          query(h); chk("R6 random claim", {7'b0, h}, {7'b0, act});
          if (act) blk_m = 1'b1;
        end
        default: begin
          mk_m = 8'($urandom);
          ie_m = 1'($urandom);
          wr(3'd4, mk_m); wr(3'd0, {7'b0, ie_m});
        end
      endcase
      @(negedge clk);
      chk("R5 random alert", {7'b0, alert_no}, {7'b0, exp_alert_n(ie_m, st_m, mk_m, blk_m)});
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule